// File: doc/BRIEF.md
# DMA Channel Trigger Queue

This block holds trigger events for a set of DMA channels (64 by default). Events come from three sources, each with its own per-channel pending register. The first source is hardware request lines, qualified by an enable mask. The second is a software manual-set write, which ignores that mask. The third is the completion code of a finished transfer, which chains into the channel it names. Pending events that are not yet queued enter a single FIFO of channel indices, one per cycle, lowest channel number first.

The entry at the head of the FIFO is checked against a per-channel null flag. A non-null channel is offered as a transfer request on a valid/ready handshake, with its channel index and the source that triggered it. A null channel is dropped without a request: its pending bit is cleared and its miss bit is set. A trigger that arrives while the same source already has that channel pending also sets the miss bit, and no second entry is queued. The miss register is sticky. Software clears a miss bit by writing 1 to it on a separate port.

Top module: `dma_trig_queue`

## Requirements
- R1: After reset the miss register is all zero, `q_empty` is 1, `q_full` is 0 and `tr_valid` is 0.
- R2: `hw_evt[n]` sampled high while `hw_en[n]` is 1 makes channel n pending from the hardware source (source code 0). While `hw_en[n]` is 0 the line has no effect.
- R3: A manual-set bit `man_set[n]` sampled high makes channel n pending from the manual source (source code 2), whatever the value of `hw_en[n]`.
- R4: `cmpl_valid` sampled high makes the channel numbered by `cmpl_code` pending from the chained source (source code 1).
- R5: Pending, not-yet-queued events enter the FIFO one per cycle. The lowest channel index goes first. Within one channel the order is hardware, then chained, then manual.
- R6: The head of the FIFO is offered with `tr_valid`, `tr_chan` and `tr_src`. It stays there until a cycle with `tr_valid` and `tr_ready` both high. That handshake pops it and clears its pending bit, so the channel can be triggered again.
- R7: When the head channel has `null_set` high, no request is offered. The entry is popped, its pending bit is cleared and its miss bit is set. A later trigger of that channel is accepted as new.
- R8: A trigger from a source whose pending bit for that channel is still set sets the channel's miss bit and adds no FIFO entry.
- R9: The three sources keep independent pending bits. Triggers for the same channel from two sources produce two separate requests.
- R10: A miss bit stays set until a cycle with `miss_clr` high for that bit. A new miss in the same cycle wins over the clear.
- R11: The FIFO holds QDEPTH (16) entries and raises `q_full` when full. Pending events wait while it is full and are queued, in order, once space frees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_evt | input | NCH | Hardware request lines, one per channel |
| hw_en | input | NCH | Enable mask for the hardware lines |
| man_set | input | NCH | Manual-set write, 1 triggers the channel |
| cmpl_valid | input | 1 | A chained completion is reported this cycle |
| cmpl_code | input | log2(NCH) | Channel index named by the completion code |
| null_set | input | NCH | Per-channel flag: parameter set is null |
| miss_clr | input | NCH | Write-1-to-clear for miss bits |
| tr_valid | output | 1 | Transfer request offered |
| tr_ready | input | 1 | Transfer request accepted |
| tr_chan | output | log2(NCH) | Channel of the offered request |
| tr_src | output | 2 | Trigger source: 0 hardware, 1 chained, 2 manual |
| miss | output | NCH | Sticky per-channel miss register |
| q_full | output | 1 | FIFO full |
| q_empty | output | 1 | FIFO empty |

## Verification
A trigger sampled at edge k sets its pending bit at k. The event is queued at k+1, so `tr_valid` can be seen after k+1. A duplicate trigger sets its miss bit at the same edge k. A null head is dropped one edge after it reaches the head, and its miss bit is set at that edge. The scoreboard compares each handshake against an ordered list of expected channel/source pairs, so exact cycles do not matter for requests. The flag and miss checks are sampled at a falling edge only after enough cycles for every register on the path to settle. Stimulus is applied one time unit after a rising edge, so every input is sampled exactly once.

// File: rtl/dma_trig_queue.sv
module dma_trig_queue #(
  parameter int NCH    = 64,
  parameter int QDEPTH = 16,
  localparam int CW    = $clog2(NCH),
  localparam int AW    = $clog2(QDEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hw_evt,
  input  logic [NCH-1:0] hw_en,
  input  logic [NCH-1:0] man_set,
  input  logic           cmpl_valid,
  input  logic [CW-1:0]  cmpl_code,
  input  logic [NCH-1:0] null_set,
  input  logic [NCH-1:0] miss_clr,
  output logic           tr_valid,
  input  logic           tr_ready,
  output logic [CW-1:0]  tr_chan,
  output logic [1:0]     tr_src,
  output logic [NCH-1:0] miss,
  output logic           q_full,
  output logic           q_empty
);
  localparam logic [NCH-1:0] ONE = {{(NCH-1){1'b0}}, 1'b1};

  logic [NCH-1:0] pend_hw, pend_ch, pend_mn;
  logic [NCH-1:0] qd_hw, qd_ch, qd_mn;
  logic [CW+1:0]  mem [QDEPTH];
  logic [AW-1:0]  wr_ptr, rd_ptr;
  logic [AW:0]    count;

  wire [NCH-1:0] trg_hw = hw_evt & hw_en;
  wire [NCH-1:0] trg_ch = cmpl_valid ? (ONE << cmpl_code) : '0;
  wire [NCH-1:0] trg_mn = man_set;

  wire [NCH-1:0] cand_hw = pend_hw & ~qd_hw;
  wire [NCH-1:0] cand_ch = pend_ch & ~qd_ch;
  wire [NCH-1:0] cand_mn = pend_mn & ~qd_mn;
  wire [NCH-1:0] cand    = cand_hw | cand_ch | cand_mn;

  logic [CW-1:0] pick;
  logic          found;
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = NCH - 1; i >= 0; i--)
      if (cand[i]) begin
        pick  = CW'(i);
        found = 1'b1;
      end
  end

  wire [1:0] pick_src = cand_hw[pick] ? 2'd0 : cand_ch[pick] ? 2'd1 : 2'd2;

  assign q_full  = count == (AW+1)'(QDEPTH);
  assign q_empty = count == '0;

  wire       enq   = found && !q_full;
  wire [CW-1:0] hchan = mem[rd_ptr][CW-1:0];
  wire [1:0]    hsrc  = mem[rd_ptr][CW+1:CW];
  wire       hnull = !q_empty && null_set[hchan];

  assign tr_valid = !q_empty && !null_set[hchan];
  assign tr_chan  = hchan;
  assign tr_src   = hsrc;

  wire pop = hnull || (tr_valid && tr_ready);

  wire [NCH-1:0] svc    = pop ? (ONE << hchan) : '0;
  wire [NCH-1:0] clr_hw = (hsrc == 2'd0) ? svc : '0;
  wire [NCH-1:0] clr_ch = (hsrc == 2'd1) ? svc : '0;
  wire [NCH-1:0] clr_mn = (hsrc == 2'd2) ? svc : '0;

  wire [NCH-1:0] ins    = enq ? (ONE << pick) : '0;
  wire [NCH-1:0] ins_hw = (pick_src == 2'd0) ? ins : '0;
  wire [NCH-1:0] ins_ch = (pick_src == 2'd1) ? ins : '0;
  wire [NCH-1:0] ins_mn = (pick_src == 2'd2) ? ins : '0;

  wire [NCH-1:0] dup  = (trg_hw & pend_hw) | (trg_ch & pend_ch) | (trg_mn & pend_mn);
  wire [NCH-1:0] drop = hnull ? (ONE << hchan) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_hw <= '0; pend_ch <= '0; pend_mn <= '0;
      qd_hw   <= '0; qd_ch   <= '0; qd_mn   <= '0;
      miss    <= '0;
      wr_ptr  <= '0; rd_ptr  <= '0; count <= '0;
    end else begin
      pend_hw <= (pend_hw | trg_hw) & ~clr_hw;
      pend_ch <= (pend_ch | trg_ch) & ~clr_ch;
      pend_mn <= (pend_mn | trg_mn) & ~clr_mn;
      qd_hw   <= (qd_hw | ins_hw) & ~clr_hw;
      qd_ch   <= (qd_ch | ins_ch) & ~clr_ch;
      qd_mn   <= (qd_mn | ins_mn) & ~clr_mn;
      miss    <= (miss & ~miss_clr) | dup | drop;
      if (enq) wr_ptr <= (wr_ptr == AW'(QDEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop) rd_ptr <= (rd_ptr == AW'(QDEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + (AW+1)'(enq) - (AW+1)'(pop);
    end
  end

  always_ff @(posedge clk)
    if (enq) mem[wr_ptr] <= {pick_src, pick};
endmodule

module dma_trig_queue_chk #(
  parameter int NCH = 64,
  localparam int CW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] miss,
  input logic [NCH-1:0] miss_clr,
  input logic [NCH-1:0] man_set,
  input logic [NCH-1:0] pend_mn,
  input logic [NCH-1:0] null_set,
  input logic           tr_valid,
  input logic           tr_ready,
  input logic [CW-1:0]  tr_chan,
  input logic [1:0]     tr_src,
  input logic           q_full,
  input logic           q_empty
);
  a_r1_empty_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty |-> !tr_valid);

  a_r5_source_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    tr_valid |-> tr_src != 2'd3);

  a_r6_head_kept_without_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && !tr_ready) |=> !q_empty);

  a_r7_null_head_sets_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_empty && null_set[tr_chan]) |=> miss[$past(tr_chan)]);

  a_r8_manual_dup_sets_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (|(man_set & pend_mn)) |=> ((miss & $past(man_set & pend_mn)) == $past(man_set & pend_mn)));

  a_r10_miss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(miss) & ~$past(miss_clr) & ~miss) == '0));

  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_full && q_empty));
endmodule

bind dma_trig_queue dma_trig_queue_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/test_dma_trig_queue.sv
module test_dma_trig_queue;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 64;
  localparam int CW  = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] hw_evt = '0, hw_en = '0, man_set = '0, null_set = '0, miss_clr = '0;
  logic           cmpl_valid = 1'b0;
  logic [CW-1:0]  cmpl_code = '0;
  logic           tr_ready = 1'b1;
  logic           tr_valid, q_full, q_empty;
  logic [CW-1:0]  tr_chan;
  logic [1:0]     tr_src;
  logic [NCH-1:0] miss;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct { logic [1:0] src; logic [CW-1:0] ch; string req; } item_t;
  item_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_trig_queue #(.NCH(NCH), .QDEPTH(16)) i_dma_trig_queue (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_tr(logic [1:0] s, int c, string req);
    item_t it;
    it.src = s; it.ch = CW'(c); it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sample;
    @(negedge clk);
  endtask

  task automatic drain(string req);
    for (int k = 0; k < 300 && exp_q.size() > 0; k++) step(1);
    step(4);
    sample();
    chk({req, " all expected requests seen"}, 64'(exp_q.size()), 64'd0);
    chk({req, " queue empty after drain"}, 64'(q_empty), 64'd1);
  endtask

  always @(negedge clk) begin
    if (rst_n && tr_valid && tr_ready) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected request: actual src %0d chan %0d expected none", tr_src, tr_chan);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        if (tr_src !== e.src || tr_chan !== e.ch) begin
          n_fail++;
          $display("FAIL %s: actual src %0d chan %0d expected src %0d chan %0d",
                   e.req, tr_src, tr_chan, e.src, e.ch);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    sample();
    chk("R1 miss after reset", miss, 64'd0);
    chk("R1 empty after reset", q_empty, 1);
    chk("R1 full after reset", q_full, 0);
    chk("R1 no request after reset", tr_valid, 0);

    // R2: enabled line queues, disabled line ignored
    step(1);
    hw_en = 64'h20;
    expect_tr(2'd0, 5, "R2");
    hw_evt = 64'h60;
    step(1);
    hw_evt = '0;
    drain("R2");
    hw_en = '0;

    // R3: manual set ignores the enable mask
    step(1);
    expect_tr(2'd2, 9, "R3");
    man_set[9] = 1'b1;
    step(1);
    man_set = '0;
    drain("R3");

    // R4: chained completion code
    expect_tr(2'd1, 40, "R4");
    cmpl_valid = 1'b1; cmpl_code = 6'd40;
    step(1);
    cmpl_valid = 1'b0;
    drain("R4");

    // R5/R6: lowest first; head held without ready
    tr_ready = 1'b0;
    expect_tr(2'd2, 3, "R5");
    expect_tr(2'd2, 17, "R5");
    expect_tr(2'd2, 30, "R5");
    man_set = (64'd1 << 30) | (64'd1 << 3) | (64'd1 << 17);
    step(1);
    man_set = '0;
    step(6);
    sample();
    chk("R6 valid held without ready", tr_valid, 1);
    chk("R6 head channel held", tr_chan, 3);
    step(1);
    tr_ready = 1'b1;
    drain("R5");

    // R9: same channel from two sources
    tr_ready = 1'b0;
    hw_en[12] = 1'b1;
    expect_tr(2'd0, 12, "R9");
    expect_tr(2'd2, 12, "R9");
    hw_evt[12] = 1'b1; man_set[12] = 1'b1;
    step(1);
    hw_evt = '0; man_set = '0; hw_en = '0;
    step(4);
    tr_ready = 1'b1;
    drain("R9");
    chk("R9 no miss for separate sources", miss[12], 0);

    // R8: duplicate manual trigger while pending
    tr_ready = 1'b0;
    expect_tr(2'd2, 20, "R8");
    man_set[20] = 1'b1;
    step(1);
    man_set = '0;
    step(3);
    man_set[20] = 1'b1;
    step(1);
    man_set = '0;
    step(2);
    sample();
    chk("R8 miss set on duplicate", miss[20], 1);
    step(1);
    tr_ready = 1'b1;
    drain("R8");

    // R10: sticky until write-1 clear
    step(10);
    sample();
    chk("R10 miss still set", miss[20], 1);
    step(1);
    miss_clr[20] = 1'b1;
    step(1);
    miss_clr = '0;
    sample();
    chk("R10 miss cleared by write", miss[20], 0);

    // R7: null set discarded, miss set, retrigger accepted
    null_set[50] = 1'b1;
    man_set[50] = 1'b1;
    step(1);
    man_set = '0;
    step(5);
    sample();
    chk("R7 miss set on null discard", miss[50], 1);
    chk("R7 entry removed", q_empty, 1);
    step(1);
    null_set = '0;
    miss_clr[50] = 1'b1;
    step(1);
    miss_clr = '0;
    expect_tr(2'd2, 50, "R7");
    man_set[50] = 1'b1;
    step(1);
    man_set = '0;
    drain("R7");
    chk("R7 retrigger not a miss", miss[50], 0);

    // R11: fill beyond depth
    tr_ready = 1'b0;
    for (int c = 0; c < 20; c++) expect_tr(2'd2, c, "R11");
    man_set = 64'h000F_FFFF;
    step(1);
    man_set = '0;
    step(25);
    sample();
    chk("R11 full flag", q_full, 1);
    chk("R11 not empty when full", q_empty, 0);
    step(1);
    tr_ready = 1'b1;
    drain("R11");
    chk("R11 no miss from waiting", miss, 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule